// File: doc/BRIEF.md
# Granule Protection Check Stage

This block sits between the address translation pipeline and the cache. Each incoming transaction carries a fully translated physical address and the security world of its requester. The stage finds the 4 KB granule the address falls in and looks up that granule's ownership code in an internal table. If the requester is allowed to touch the granule, the transaction goes on to the downstream port. If not, the stage consumes the transaction and reports a protection fault carrying the address and the world. It does not matter which translation stage produced the address. No transaction moves past this point until it has been checked.

The ownership table is written through a separate update port. Only the root world may use it. An update from any other world is refused, raises an error pulse, and leaves the table as it was. Both the request side and the forward side use valid/ready handshakes. The lookup is registered, so it takes one cycle.

Top module: `gpc_stage`

## Requirements
- R1: World codes are 0 normal, 1 secure, 2 realm, 3 root. Granule state codes are 0 normal, 1 secure, 2 realm, 3 root, 4 shared-with-all. After reset every granule holds code 0.
- R2: A request whose world code equals its granule's state code, or whose granule holds code 4, appears on the forward port with its address and world unchanged.
- R3: A request that fails the check is never forwarded. Instead `faultValid` pulses for one cycle with the request's address and world. Forward and fault are never valid together.
- R4: State codes 5, 6 and 7 fault for requests from every world, root included.
- R5: Root requests get no exemption. For example, a root request to a realm granule faults.
- R6: An update from world 3 writes `updState` into granule `updIdx`. An update from any other world leaves the table unchanged and pulses `updErr` in the following cycle. A root update leaves `updErr` low.
- R7: A request accepted on a clock edge is shown on the forward or fault outputs in the very next cycle. `reqReady` is high when the stage is empty or is emptying in that cycle.
- R8: While `fwdValid` is high and `fwdReady` is low, the forward outputs hold steady and no new request is taken. A faulting request drains without `fwdReady`.
- R9: The granule index is `reqAddr[ADDR_W-1:GRAN_SHIFT]`. The bits below that index do not affect the outcome.
- R10: A request accepted on the same edge as a table write sees the granule's old state. Requests accepted afterwards see the new state.
- R11: During and straight after reset, `reqReady` is high and `fwdValid`, `faultValid` and `updErr` are low.

Ports use the parameters ADDR_W (physical address width), GRAN_SHIFT (log2 of the granule size, 12) and IDX_W = ADDR_W - GRAN_SHIFT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Translated request present |
| reqReady | output | 1 | Stage can take a request |
| reqAddr | input | ADDR_W | Physical address of the request |
| reqWorld | input | 2 | Requester world code |
| fwdValid | output | 1 | Checked request offered downstream |
| fwdReady | input | 1 | Downstream takes the request |
| fwdAddr | output | ADDR_W | Forwarded address |
| fwdWorld | output | 2 | Forwarded world |
| faultValid | output | 1 | Protection fault pulse |
| faultAddr | output | ADDR_W | Address of the faulting request |
| faultWorld | output | 2 | World of the faulting request |
| updValid | input | 1 | Table update strobe |
| updWorld | input | 2 | World issuing the update |
| updIdx | input | IDX_W | Granule to update |
| updState | input | 3 | New state code |
| updErr | output | 1 | Refused-update pulse |

## Verification
The bench builds the stage with ADDR_W = 16, which gives a 16-granule table. With a table that small, a directed sweep covers every state code, including the three unused ones, against every world. Random traffic also hits the same granule often enough to reach same-edge update and lookup collisions. The random phase toggles downstream backpressure as well, so stalled forwards, faults draining under a stall, and refused updates from each non-root world all occur many times.

// File: rtl/gpc_pkg.sv
package gpc_pkg;

  localparam logic [1:0] WORLD_NONSEC = 2'd0;
  localparam logic [1:0] WORLD_SECURE = 2'd1;
  localparam logic [1:0] WORLD_REALM  = 2'd2;
  localparam logic [1:0] WORLD_ROOT   = 2'd3;

  localparam logic [2:0] GST_NONSEC = 3'd0;
  localparam logic [2:0] GST_SECURE = 3'd1;
  localparam logic [2:0] GST_REALM  = 3'd2;
  localparam logic [2:0] GST_ROOT   = 3'd3;
  localparam logic [2:0] GST_ANY    = 3'd4;

  typedef struct packed {
    logic load;   // capture request and table read into the stage
    logic tblWr;  // commit an authorised table update
  } gpcStrobe_t;

  // Access granted when the state is shared, or names the requester's world.
  // Codes 5..7 never match a 2-bit world and are not shared, so they fault.
  function automatic logic accessGranted(input logic [1:0] world,
                                         input logic [2:0] gstate);
    return (gstate == GST_ANY) || (gstate == {1'b0, world});
  endfunction

endpackage

// File: rtl/gpc_datapath.sv
module gpc_datapath
  import gpc_pkg::*;
#(
  parameter int ADDR_W     = 20,
  parameter int GRAN_SHIFT = 12,
  localparam int IDX_W     = ADDR_W - GRAN_SHIFT,
  localparam int GRAN_CNT  = 1 << IDX_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  gpcStrobe_t        strobes,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [1:0]        reqWorld,
  input  logic [IDX_W-1:0]  updIdx,
  input  logic [2:0]        updState,
  output logic [ADDR_W-1:0] stageAddr,
  output logic [1:0]        stageWorld,
  output logic [2:0]        stageState
);

  logic [2:0]       granTbl [GRAN_CNT];
  logic [IDX_W-1:0] reqIdx;

  assign reqIdx = reqAddr[ADDR_W-1:GRAN_SHIFT];

  // One state register per granule, each with its own write decode.
  for (genvar g = 0; g < GRAN_CNT; g++) begin : gEntry
    always_ff @(posedge clk) begin
      if (!rstN)
        granTbl[g] <= GST_NONSEC;
      else if (strobes.tblWr && (updIdx == IDX_W'(g)))
        granTbl[g] <= updState;
    end
  end

  // Registered lookup: the read happens before any same-edge write lands.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      stageAddr  <= '0;
      stageWorld <= WORLD_NONSEC;
      stageState <= GST_NONSEC;
    end else if (strobes.load) begin
      stageAddr  <= reqAddr;
      stageWorld <= reqWorld;
      stageState <= granTbl[reqIdx];
    end
  end

endmodule

// File: rtl/gpc_ctrl.sv
module gpc_ctrl
  import gpc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  output logic       reqReady,
  input  logic       fwdReady,
  output logic       fwdValid,
  output logic       faultValid,
  input  logic       updValid,
  input  logic [1:0] updWorld,
  output logic       updErr,
  input  logic [1:0] stageWorld,
  input  logic [2:0] stageState,
  output gpcStrobe_t strobes
);

  logic stageValid;
  logic granted;
  logic drain;
  logic accept;
  logic updIsRoot;

  assign granted    = accessGranted(stageWorld, stageState);
  assign fwdValid   = stageValid && granted;
  assign faultValid = stageValid && !granted;
  // A faulting entry leaves unconditionally; a granted one needs fwdReady.
  assign drain      = stageValid && (!granted || fwdReady);
  assign reqReady   = !stageValid || drain;
  assign accept     = reqValid && reqReady;
  assign updIsRoot  = (updWorld == WORLD_ROOT);

  always_comb begin
    strobes       = '0;
    strobes.load  = accept;
    strobes.tblWr = updValid && updIsRoot;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stageValid <= 1'b0;
      updErr     <= 1'b0;
    end else begin
      if (accept)
        stageValid <= 1'b1;
      else if (drain)
        stageValid <= 1'b0;
      updErr <= updValid && !updIsRoot;
    end
  end

endmodule

// File: rtl/gpc_stage.sv
module gpc_stage
  import gpc_pkg::*;
#(
  parameter int ADDR_W     = 20,
  parameter int GRAN_SHIFT = 12,
  localparam int IDX_W     = ADDR_W - GRAN_SHIFT
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [1:0]        reqWorld,
  output logic              fwdValid,
  input  logic              fwdReady,
  output logic [ADDR_W-1:0] fwdAddr,
  output logic [1:0]        fwdWorld,
  output logic              faultValid,
  output logic [ADDR_W-1:0] faultAddr,
  output logic [1:0]        faultWorld,
  input  logic              updValid,
  input  logic [1:0]        updWorld,
  input  logic [IDX_W-1:0]  updIdx,
  input  logic [2:0]        updState,
  output logic              updErr
);

  gpcStrobe_t        strobes;
  logic [ADDR_W-1:0] stageAddr;
  logic [1:0]        stageWorld;
  logic [2:0]        stageState;

  gpc_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .reqReady   (reqReady),
    .fwdReady   (fwdReady),
    .fwdValid   (fwdValid),
    .faultValid (faultValid),
    .updValid   (updValid),
    .updWorld   (updWorld),
    .updErr     (updErr),
    .stageWorld (stageWorld),
    .stageState (stageState),
    .strobes    (strobes)
  );

  gpc_datapath #(
    .ADDR_W     (ADDR_W),
    .GRAN_SHIFT (GRAN_SHIFT)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .reqAddr    (reqAddr),
    .reqWorld   (reqWorld),
    .updIdx     (updIdx),
    .updState   (updState),
    .stageAddr  (stageAddr),
    .stageWorld (stageWorld),
    .stageState (stageState)
  );

  assign fwdAddr    = stageAddr;
  assign fwdWorld   = stageWorld;
  assign faultAddr  = stageAddr;
  assign faultWorld = stageWorld;

endmodule

// File: rtl/gpc_stage_sva.sv
module gpc_stage_sva #(
  parameter int ADDR_W = 20
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqReady,
  input logic              fwdValid,
  input logic              fwdReady,
  input logic [ADDR_W-1:0] fwdAddr,
  input logic [1:0]        fwdWorld,
  input logic              faultValid,
  input logic              updValid,
  input logic [1:0]        updWorld,
  input logic              updErr
);

  assert_fwd_fault_exclusive_R3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({fwdValid, faultValid}));

  assert_accept_next_cycle_R7: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> (fwdValid || faultValid));

  assert_stall_holds_R8: assert property (@(posedge clk) disable iff (!rstN)
    (fwdValid && !fwdReady) |=> (fwdValid && $stable(fwdAddr) && $stable(fwdWorld)));

  assert_stall_blocks_req_R8: assert property (@(posedge clk) disable iff (!rstN)
    (fwdValid && !fwdReady) |-> !reqReady);

  assert_fault_drains_R8: assert property (@(posedge clk) disable iff (!rstN)
    faultValid |-> reqReady);

  assert_nonroot_refused_R6: assert property (@(posedge clk) disable iff (!rstN)
    (updValid && updWorld != 2'd3) |=> updErr);

  assert_root_accepted_R6: assert property (@(posedge clk) disable iff (!rstN)
    (updValid && updWorld == 2'd3) |=> !updErr);

endmodule

bind gpc_stage gpc_stage_sva #(.ADDR_W(ADDR_W)) u_sva (
  .clk        (clk),
  .rstN       (rstN),
  .reqValid   (reqValid),
  .reqReady   (reqReady),
  .fwdValid   (fwdValid),
  .fwdReady   (fwdReady),
  .fwdAddr    (fwdAddr),
  .fwdWorld   (fwdWorld),
  .faultValid (faultValid),
  .updValid   (updValid),
  .updWorld   (updWorld),
  .updErr     (updErr)
);

// File: tb/tb_gpc_stage.sv
module tb_gpc_stage;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 16;
  localparam int GRAN_SHIFT = 12;
  localparam int IDX_W      = ADDR_W - GRAN_SHIFT;
  localparam int GRANS      = 1 << IDX_W;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic              rv = 0, fr = 1, uv = 0;
  logic [ADDR_W-1:0] ra = '0;
  logic [1:0]        rw = '0, uw = '0;
  logic [IDX_W-1:0]  ui = '0;
  logic [2:0]        us = '0;

  logic              reqReady, fwdValid, faultValid, updErr;
  logic [ADDR_W-1:0] fwdAddr, faultAddr;
  logic [1:0]        fwdWorld, faultWorld;

  gpc_stage #(.ADDR_W(ADDR_W), .GRAN_SHIFT(GRAN_SHIFT)) dut (
    .clk(clk), .rstN(rstN),
    .reqValid(rv), .reqReady(reqReady), .reqAddr(ra), .reqWorld(rw),
    .fwdValid(fwdValid), .fwdReady(fr), .fwdAddr(fwdAddr), .fwdWorld(fwdWorld),
    .faultValid(faultValid), .faultAddr(faultAddr), .faultWorld(faultWorld),
    .updValid(uv), .updWorld(uw), .updIdx(ui), .updState(us), .updErr(updErr)
  );

  int checks = 0;
  int errors = 0;

  // Behavioural reference model
  int          mTbl [GRANS];
  bit          mValid = 0;
  int          mAddr = 0, mWorld = 0, mState = 0;
  bit          mErr = 0;

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit granted(input int w, input int s);
    return (s == 4) || (s == w);
  endfunction

  // Compare outputs against the model, then advance the model one edge.
  task automatic tick();
    bit pass, drain, rdy;
    #1;
    pass  = granted(mWorld, mState);
    drain = mValid && (!pass || fr);
    rdy   = !mValid || drain;
    check("R7 reqReady", int'(reqReady), int'(rdy));
    check("R2 fwdValid", int'(fwdValid), int'(mValid && pass));
    check("R3 faultValid", int'(faultValid), int'(mValid && !pass));
    if (mValid && pass) begin
      check("R2 fwdAddr", int'(fwdAddr), mAddr);
      check("R2 fwdWorld", int'(fwdWorld), mWorld);
    end
    if (mValid && !pass) begin
      check("R3 faultAddr", int'(faultAddr), mAddr);
      check("R3 faultWorld", int'(faultWorld), mWorld);
    end
    check("R6 updErr", int'(updErr), int'(mErr));
    if (rv && rdy) begin
      mValid = 1;
      mAddr  = int'(ra);
      mWorld = int'(rw);
      mState = mTbl[int'(ra[ADDR_W-1:GRAN_SHIFT])];
    end else if (drain) begin
      mValid = 0;
    end
    mErr = uv && (uw != 2'd3);
    if (uv && uw == 2'd3) mTbl[int'(ui)] = int'(us);
    @(negedge clk);
  endtask

  task automatic sendReq(input int gran, input int world);
    rv = 1;
    ra = {IDX_W'(gran), GRAN_SHIFT'($urandom)};
    rw = 2'(world);
    tick();
    rv = 0;
  endtask

  task automatic writeGran(input int world, input int gran, input int st);
    uv = 1; uw = 2'(world); ui = IDX_W'(gran); us = 3'(st);
    tick();
    uv = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < GRANS; i++) mTbl[i] = 0;
    repeat (3) @(negedge clk);
    // R11: outputs quiet while reset is held
    #1;
    check("R11 reqReady in reset", int'(reqReady), 1);
    check("R11 fwdValid in reset", int'(fwdValid), 0);
    check("R11 faultValid in reset", int'(faultValid), 0);
    check("R11 updErr in reset", int'(updErr), 0);
    @(negedge clk);
    rstN = 1;
    tick();

    // R1: every granule resets to normal; normal world passes, others fault
    for (int g = 0; g < GRANS; g++) begin
      sendReq(g, 0);
      check("R1 reset state passes normal", int'(fwdValid), 1);
    end
    sendReq(5, 2);
    check("R1 realm on reset granule faults", int'(faultValid), 1);

    // R6: non-root updates refused, table untouched
    writeGran(1, 2, 2);
    check("R6 secure update refused", int'(updErr), 1);
    writeGran(2, 2, 2);
    writeGran(0, 2, 2);
    sendReq(2, 0);
    check("R6 table unchanged after refusal", int'(fwdValid), 1);

    // Root programs one granule per code, including unused codes
    for (int s = 0; s < 8; s++) writeGran(3, s, s);
    tick();
    check("R6 root update no error", int'(updErr), 0);

    // R2/R3/R4/R5: sweep every world against every code
    for (int w = 0; w < 4; w++)
      for (int s = 0; s < 8; s++) begin
        sendReq(s, w);
        if (s >= 5) check("R4 unused code faults", int'(faultValid), 1);
        else if (s == 4) check("R2 shared granule passes", int'(fwdValid), 1);
        else check("R5 world match rule", int'(fwdValid), int'(s == w));
      end
    sendReq(2, 3);
    check("R5 root to realm faults", int'(faultValid), 1);

    // R9: offset bits do not change the outcome
    rv = 1; ra = {IDX_W'(1), {GRAN_SHIFT{1'b1}}}; rw = 2'd1; tick(); rv = 0;
    check("R9 high offset same granule", int'(fwdValid), 1);
    rv = 1; ra = {IDX_W'(1), {GRAN_SHIFT{1'b0}}}; rw = 2'd1; tick(); rv = 0;
    check("R9 zero offset same granule", int'(fwdValid), 1);

    // R8: backpressure holds the forward and blocks input
    fr = 0;
    sendReq(4, 1);
    rv = 1; ra = {IDX_W'(0), GRAN_SHIFT'(0)}; rw = 2'd0;
    for (int k = 0; k < 4; k++) begin
      tick();
      check("R8 stall blocks req", int'(reqReady), 0);
    end
    fr = 1;
    tick();
    rv = 0;
    tick();
    // R8: a fault drains even with fwdReady low
    fr = 0;
    sendReq(3, 0);
    check("R8 fault under stall", int'(faultValid), 1);
    #1;
    check("R8 fault drains without ready", int'(reqReady), 1);
    fr = 1;
    tick();

    // R10: same-edge write is not seen by the request accepted on it
    uv = 1; uw = 2'd3; ui = IDX_W'(9); us = 3'd2;
    sendReq(9, 0);
    uv = 0;
    check("R10 old state on same edge", int'(fwdValid), 1);
    sendReq(9, 0);
    check("R10 new state afterwards", int'(faultValid), 1);

    // Random traffic with backpressure and updates
    for (int n = 0; n < 4000; n++) begin
      rv = 1'($urandom_range(0, 3) != 0);
      ra = ADDR_W'($urandom);
      rw = 2'($urandom);
      fr = 1'($urandom_range(0, 2) != 0);
      uv = 1'($urandom_range(0, 5) == 0);
      uw = 2'($urandom);
      ui = IDX_W'($urandom);
      us = 3'($urandom_range(0, 5));
      tick();
    end
    rv = 0; uv = 0; fr = 1;
    tick();
    tick();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule